// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Interlock

This block sits between a commutation decoder and the six gate drivers of a three-phase bridge, where each phase has a high-side and a low-side switch. It registers the requested drive levels and gates them so that the two switches of one phase are never on together. After a switch turns off, its opposite partner must wait a programmable dead time before it can turn on. The dead time is measured in ticks of the PWM oscillator and is two ticks by default.

Each switch has a "recently active" flag. The flag is set while the switch is driven. It stays set after turn-off until the dead-time countdown expires, and while it is set it holds off the opposite switch of the same phase. A turn-on request that is blocked in this way is not lost: the switch turns on as soon as the opposing flag clears, provided the request is still present. A supply-lockout input forces all outputs off while the supply is too low to drive the switches safely.

Top module: `hb_interlock`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, all six outputs are low and every dead-time flag is clear.
- R2: With the supply good, the opposing flag clear and only one switch of a phase requested, that output goes high on the next clock edge. It goes low on the clock edge after its request drops.
- R3: The high-side and low-side outputs of the same phase are never high in the same cycle.
- R4: A switch's flag is set while its output is high. After the output goes low, the flag stays set until DEAD_TICKS pwm_tick pulses have been sampled, counting only clock edges after the first edge that follows the turn-off.
- R5: A request for a switch whose opposing flag is set leaves that output low. The output goes high on the clock edge after the opposing flag clears, if the request is still held.
- R6: If both switches of a phase are requested while both of that phase's flags are clear, both outputs stay low until only one request remains.
- R7: When uvlo_ok is low, all outputs are low from the next clock edge and requests are ignored. Dead-time countdowns still advance on pwm_tick.
- R8: When a switch turns off again during its countdown, the countdown restarts from DEAD_TICKS.
- R9: Each phase is gated only by its own requests and flags. A countdown in one phase does not delay the other phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_tick | input | 1 | One-cycle pulse per PWM oscillator period |
| uvlo_ok | input | 1 | High when the supply is adequate for driving |
| req_hi | input | NUM_PHASES | Requested high-side drive, bit i is phase i (bit 0 = A) |
| req_lo | input | NUM_PHASES | Requested low-side drive, bit i is phase i |
| drv_hi | output | NUM_PHASES | Gated high-side drive |
| drv_lo | output | NUM_PHASES | Gated low-side drive |

## Verification
The bench uses the default parameters: three phases and a dead time of two PWM ticks. With a two-tick dead time, each tick can be counted one by one, so the bench can observe the opposing output held low after the first tick, still low on the edge where the countdown ends, and high exactly one clock later. With three phases, the bench can hold one phase in its countdown while a second phase switches freely and a third stays idle. This is how it checks that each phase is gated independently.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Gating decision for one phase: returns {hi_next, lo_next}.
  function automatic logic [1:0] gate_pair(input logic uv_ok,
                                           input logic rq_hi,
                                           input logic rq_lo,
                                           input logic fl_hi,
                                           input logic fl_lo);
    logic contest;
    contest = rq_hi & rq_lo & ~fl_hi & ~fl_lo;
    if (!uv_ok || contest) return 2'b00;
    return {rq_hi & ~fl_lo, rq_lo & ~fl_hi};
  endfunction

endpackage

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int unsigned DEAD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic drv,
  output logic fall,
  output logic busy
);
  localparam int unsigned CW = hb_pkg::cnt_width(DEAD_TICKS);

  logic          drv_d;
  logic [CW-1:0] cnt;

  assign fall = drv_d & ~drv;
  assign busy = drv | fall | (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_d <= 1'b0;
      cnt   <= '0;
    end else begin
      drv_d <= drv;
      if (fall)
        cnt <= CW'(DEAD_TICKS);
      else if (drv)
        cnt <= '0;
      else if (tick && cnt != '0)
        cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/hb_phase_gate.sv
module hb_phase_gate #(
  parameter int unsigned DEAD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uv_ok,
  input  logic rq_hi,
  input  logic rq_lo,
  output logic drv_hi,
  output logic drv_lo,
  output logic flag_hi,
  output logic flag_lo
);
  logic [1:0] nxt;
  logic       fall_hi, fall_lo;

  assign nxt = hb_pkg::gate_pair(uv_ok, rq_hi, rq_lo, flag_hi, flag_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_hi <= 1'b0;
      drv_lo <= 1'b0;
    end else begin
      drv_hi <= nxt[1];
      drv_lo <= nxt[0];
    end
  end

  hb_dead_timer #(.DEAD_TICKS(DEAD_TICKS)) hi_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drv(drv_hi),
    .fall(fall_hi), .busy(flag_hi)
  );

  hb_dead_timer #(.DEAD_TICKS(DEAD_TICKS)) lo_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drv(drv_lo),
    .fall(fall_lo), .busy(flag_lo)
  );
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
  parameter int unsigned NUM_PHASES = 3,
  parameter int unsigned DEAD_TICKS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwm_tick,
  input  logic                  uvlo_ok,
  input  logic [NUM_PHASES-1:0] req_hi,
  input  logic [NUM_PHASES-1:0] req_lo,
  output logic [NUM_PHASES-1:0] drv_hi,
  output logic [NUM_PHASES-1:0] drv_lo
);
  // Dead-time flags, named for the bound checker.
  logic [NUM_PHASES-1:0] flag_hi;
  logic [NUM_PHASES-1:0] flag_lo;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    hb_phase_gate #(.DEAD_TICKS(DEAD_TICKS)) gate_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (pwm_tick),
      .uv_ok  (uvlo_ok),
      .rq_hi  (req_hi[p]),
      .rq_lo  (req_lo[p]),
      .drv_hi (drv_hi[p]),
      .drv_lo (drv_lo[p]),
      .flag_hi(flag_hi[p]),
      .flag_lo(flag_lo[p])
    );
  end
endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk #(
  parameter int unsigned NUM_PHASES = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwm_tick,
  input logic                  uvlo_ok,
  input logic [NUM_PHASES-1:0] drv_hi,
  input logic [NUM_PHASES-1:0] drv_lo,
  input logic [NUM_PHASES-1:0] flag_hi,
  input logic [NUM_PHASES-1:0] flag_lo
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi & drv_lo) == '0);

  // R7
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (drv_hi == '0 && drv_lo == '0));

  // R4
  flag_covers_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_hi & ~flag_hi) == '0) && ((drv_lo & ~flag_lo) == '0));

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
    // R5
    hi_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_hi[p]) |-> $past(!flag_lo[p]));
    // R5
    lo_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_lo[p]) |-> $past(!flag_hi[p]));
    // R4
    hi_flag_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_hi[p]) |-> $past(pwm_tick));
    // R4
    lo_flag_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_lo[p]) |-> $past(pwm_tick));
  end
endmodule

bind hb_interlock hb_interlock_chk #(.NUM_PHASES(NUM_PHASES)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .uvlo_ok(uvlo_ok),
  .drv_hi(drv_hi), .drv_lo(drv_lo), .flag_hi(flag_hi), .flag_lo(flag_lo)
);

// File: tb/hb_interlock_tb.sv
module hb_interlock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_tick = 1'b0;
  logic       uvlo_ok = 1'b1;
  logic [2:0] req_hi = '0;
  logic [2:0] req_lo = '0;
  logic [2:0] drv_hi, drv_lo;
  int         n_chk = 0;
  int         n_bad = 0;
  int         overlap_seen = 0;

  always #4 clk = ~clk;

  hb_interlock #(.NUM_PHASES(3), .DEAD_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .uvlo_ok(uvlo_ok),
    .req_hi(req_hi), .req_lo(req_lo), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // R3 monitor, sampled away from the active edge
  always @(negedge clk)
    if (rst_n && (drv_hi & drv_lo) != 3'b000) overlap_seen++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick_once();
    pwm_tick = 1'b1; step(1); pwm_tick = 1'b0;
  endtask

  // Drop all requests and let every countdown expire.
  task automatic quiesce();
    req_hi = '0; req_lo = '0; uvlo_ok = 1'b1;
    step(3);
    for (int i = 0; i < 3; i++) begin tick_once(); step(1); end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_hi = 3'b111; step(3);
    chk("R1 hi in reset", drv_hi, 3'b000);
    chk("R1 lo in reset", drv_lo, 3'b000);
    req_hi = '0; rst_n = 1'b1; step(1);
    chk("R1 hi after reset", drv_hi, 3'b000);
    chk("R1 lo after reset", drv_lo, 3'b000);
  endtask

  task automatic t_single();
    req_hi = 3'b001; step(1);
    chk("R2 hi on", drv_hi, 3'b001);
    req_hi = 3'b000; step(1);
    chk("R2 hi off", drv_hi, 3'b000);
    quiesce();
  endtask

  task automatic t_deadtime();
    req_hi = 3'b001; step(1);
    req_hi = 3'b000; req_lo = 3'b001; step(1);
    chk("R5 lo blocked at turn-off", drv_lo, 3'b000);
    step(1);
    tick_once();
    chk("R4 lo blocked after one tick", drv_lo, 3'b000);
    tick_once();
    chk("R4 lo blocked on final tick edge", drv_lo, 3'b000);
    step(1);
    chk("R5 deferred lo applied", drv_lo, 3'b001);
    quiesce();
  endtask

  task automatic t_contest();
    req_hi = 3'b001; req_lo = 3'b001; step(2);
    chk("R6 hi held off", drv_hi, 3'b000);
    chk("R6 lo held off", drv_lo, 3'b000);
    req_lo = 3'b000; step(1);
    chk("R6 hi after contest ends", drv_hi, 3'b001);
    quiesce();
  endtask

  task automatic t_lockout();
    req_hi = 3'b010; step(1);
    chk("R2 phase B hi on", drv_hi, 3'b010);
    uvlo_ok = 1'b0; step(1);
    chk("R7 hi forced off", drv_hi, 3'b000);
    req_lo = 3'b100; step(2);
    chk("R7 lo request ignored", drv_lo, 3'b000);
    uvlo_ok = 1'b1; step(1);
    chk("R7 lo after recovery", drv_lo, 3'b100);
    chk("R7 hi resumes after recovery", drv_hi, 3'b010);
    quiesce();
  endtask

  task automatic t_restart();
    req_hi = 3'b001; step(1);
    req_hi = 3'b000; step(2);
    tick_once();
    req_hi = 3'b001; step(1);
    chk("R8 hi back on mid countdown", drv_hi, 3'b001);
    req_hi = 3'b000; req_lo = 3'b001; step(2);
    tick_once();
    chk("R8 lo blocked one tick after restart", drv_lo, 3'b000);
    tick_once();
    step(1);
    chk("R8 lo on after full restarted count", drv_lo, 3'b001);
    quiesce();
  endtask

  task automatic t_independent();
    req_hi = 3'b001; step(1);
    req_hi = 3'b000; req_lo = 3'b011; step(2);
    chk("R9 B lo on while A counts", drv_lo, 3'b010);
    tick_once(); tick_once(); step(1);
    chk("R9 A lo joins after its count", drv_lo, 3'b011);
    quiesce();
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_single();
    t_deadtime();
    t_contest();
    t_lockout();
    t_restart();
    t_independent();
    n_chk++;
    if (overlap_seen != 0) begin
      n_bad++;
      $display("FAIL R3 overlap cycles: actual %0d expected 0", overlap_seen);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule